// File: doc/BRIEF.md
# Interface Time-Constant Estimator Counter

This block is the digital half of an electrode–tissue impedance estimator. A measurement raises a step-enable that drives a voltage step through a sense resistor into the load; an external comparator reports whether the sense node is still under its reference level. The block counts clock-divided periods for as long as that comparator stays high. The longer the load's RC time constant, the larger the count. When the comparator drops, the count is captured as a 3-bit code that feeds a binary-weighted stimulation-current DAC: bit 2 selects the largest current leg and bit 0 the smallest.

The comparator level is re-timed through a two-stage synchronizer. Counting only starts once the synchronized comparator has been seen high. A measurement can end in one of three ways: the comparator falls (normal), the count would pass 7 (overflow), or a programmable cycle budget runs out (timeout). During a measurement the DAC keeps the previously captured code, so the stimulation current never moves while the count is still changing.

Top module: `tau_gate_counter`

## Requirements
- R1: After reset: code_o = 3'b000, valid_o = 0, step_en_o = 0, ovf_o = 0, tmo_o = 0.
- R2: A start_i pulse while idle raises step_en_o on the next clock edge and clears valid_o, ovf_o and tmo_o. A start_i pulse while a measurement is running has no effect on its result.
- R3: While step_en_o is high, valid_o is low and code_o keeps the value captured by the previous measurement.
- R4: While the synchronized comparator is high, the count rises by one for every full TICK_DIV clocks. When the comparator is seen low, code_o takes the count as an unsigned binary value (bit 2 is the MSB and has weight 4), valid_o rises and step_en_o falls.
- R5: Periods before the synchronized comparator is first seen high are not counted. The clock on which it is first seen high is also not counted.
- R6: If an eighth full period completes with the comparator still high, the measurement ends with code_o = 3'b111 and ovf_o = 1. The count never wraps.
- R7: If a measurement has not ended after TIMEOUT_CYCLES clocks, it ends with tmo_o = 1 and valid_o = 1, and code_o is left unchanged.
- R8: cmp_i passes through two register stages before it gates counting. The outputs follow the cycle model this timing implies.
- R9: Between measurements, code_o, valid_o and the flags hold their values whatever cmp_i does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a measurement (honoured only when idle) |
| cmp_i | input | 1 | Asynchronous comparator level, high = node below reference |
| code_o | output | 3 | Captured current-DAC code |
| valid_o | output | 1 | Last measurement ended, code_o and flags are final |
| step_en_o | output | 1 | Enables the analog step during a measurement |
| ovf_o | output | 1 | Last measurement saturated at the top code |
| tmo_o | output | 1 | Last measurement ran out of its cycle budget |

## Verification
The assertions assume that start_i is a clean synchronous level. They also assume that reset is long enough to flush the synchronizer, so that cmp_i is seen low at the first idle cycle. The stimulus respects both: it changes start_i and cmp_i only on falling clock edges, and it holds cmp_i low during reset and between measurements. The comparator patterns are chosen so that the captured codes are 0, 1, 2, 3 and 7, plus an overflow. Each pattern also stays far enough from the timeout budget that only the intended ending can occur. A separate run holds the comparator low until the budget expires.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2
    } tgc_state_e;
endpackage

// File: rtl/tgc_sync.sv
module tgc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tgc_prescale.sv
module tgc_prescale #(
    parameter int TICK_DIV = 4,
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic tick_o
);
    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        tick_o = en_i && !clr_i && (div_q == DIV_W'(TICK_DIV - 1));
        div_d  = div_q;
        if (clr_i)       div_d = '0;
        else if (tick_o) div_d = '0;
        else if (en_i)   div_d = div_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/tgc_satcount.sv
module tgc_satcount #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         full_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        full_o = (cnt_q == {W{1'b1}});
        cnt_d  = cnt_q;
        if (clr_i)                cnt_d = '0;
        else if (inc_i && !full_o) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/tau_gate_counter.sv
module tau_gate_counter
    import tgc_pkg::*;
#(
    parameter int CODE_W         = 3,
    parameter int TICK_DIV       = 4,
    parameter int TIMEOUT_CYCLES = 64,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_i,
    output logic [CODE_W-1:0] code_o,
    output logic              valid_o,
    output logic              step_en_o,
    output logic              ovf_o,
    output logic              tmo_o
);
    localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    typedef struct packed {
        tgc_state_e        state;
        logic [TMR_W-1:0]  tmr;
        logic [CODE_W-1:0] code;
        logic              valid;
        logic              ovf;
        logic              tmo;
    } tgc_regs_t;

    tgc_regs_t r_d, r_q;

    logic              cmp_s;
    logic              tick;
    logic              pre_clr, pre_en;
    logic              cnt_clr, cnt_inc, cnt_full;
    logic [CODE_W-1:0] cnt;

    tgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_i),
        .q_o   (cmp_s)
    );

    tgc_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (pre_clr),
        .en_i   (pre_en),
        .tick_o (tick)
    );

    tgc_satcount #(.W(CODE_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .cnt_o  (cnt),
        .full_o (cnt_full)
    );

    always_comb begin
        r_d     = r_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        pre_en  = (r_q.state == ST_COUNT);
        pre_clr = (r_q.state != ST_COUNT);

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_ARM;
                    r_d.tmr   = '0;
                    r_d.valid = 1'b0;
                    r_d.ovf   = 1'b0;
                    r_d.tmo   = 1'b0;
                    cnt_clr   = 1'b1;
                end
            end
            ST_ARM: begin
                r_d.tmr = r_q.tmr + TMR_W'(1);
                if (cmp_s) begin
                    r_d.state = ST_COUNT;
                end else if (r_q.tmr == TMR_LAST) begin
                    r_d.state = ST_IDLE;
                    r_d.valid = 1'b1;
                    r_d.tmo   = 1'b1;
                end
            end
            ST_COUNT: begin
                r_d.tmr = r_q.tmr + TMR_W'(1);
                if (!cmp_s) begin
                    r_d.state = ST_IDLE;
                    r_d.valid = 1'b1;
                    r_d.code  = cnt;
                end else if (tick && cnt_full) begin
                    r_d.state = ST_IDLE;
                    r_d.valid = 1'b1;
                    r_d.ovf   = 1'b1;
                    r_d.code  = CODE_MAX;
                end else if (r_q.tmr == TMR_LAST) begin
                    r_d.state = ST_IDLE;
                    r_d.valid = 1'b1;
                    r_d.tmo   = 1'b1;
                end else if (tick) begin
                    cnt_inc = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.tmr   <= '0;
            r_q.code  <= '0;
            r_q.valid <= 1'b0;
            r_q.ovf   <= 1'b0;
            r_q.tmo   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign code_o    = r_q.code;
    assign valid_o   = r_q.valid;
    assign step_en_o = (r_q.state != ST_IDLE);
    assign ovf_o     = r_q.ovf;
    assign tmo_o     = r_q.tmo;
endmodule

// File: rtl/tgc_checker.sv
module tgc_checker #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              cmp_i,
    input logic [CODE_W-1:0] code_o,
    input logic              valid_o,
    input logic              step_en_o,
    input logic              ovf_o,
    input logic              tmo_o
);
    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en_o && start_i) |=> (step_en_o && !valid_o && !ovf_o && !tmo_o));

    assert_busy_not_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_en_o |-> !valid_o);

    assert_busy_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_en_o |-> $stable(code_o));

    assert_end_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_en_o) |-> valid_o);

    assert_ovf_top_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (code_o == {CODE_W{1'b1}}));

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && tmo_o));

    assert_tmo_code_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_o) |-> $stable(code_o));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en_o && !start_i) |=> ($stable(code_o) && $stable(valid_o)
                                       && $stable(ovf_o) && $stable(tmo_o)));
endmodule

bind tau_gate_counter tgc_checker #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cmp_i     (cmp_i),
    .code_o    (code_o),
    .valid_o   (valid_o),
    .step_en_o (step_en_o),
    .ovf_o     (ovf_o),
    .tmo_o     (tmo_o)
);

// File: tb/tau_gate_counter_bench.sv
`timescale 1ns/1ps
module tau_gate_counter_bench;
    localparam int DIV = 4;
    localparam int TMO = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       cmp_i = 1'b0;
    logic [2:0] code_o;
    logic       valid_o, step_en_o, ovf_o, tmo_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tau_gate_counter #(.CODE_W(3), .TICK_DIV(DIV), .TIMEOUT_CYCLES(TMO), .SYNC_STAGES(2))
    u_tau_gate_counter (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .code_o(code_o), .valid_o(valid_o), .step_en_o(step_en_o),
        .ovf_o(ovf_o), .tmo_o(tmo_o)
    );

    // behavioural reference: comparator history queue and a phase number
    bit hist[$];
    int m_phase, m_el, m_ticks, m_sub, m_code;
    bit m_valid, m_ovf, m_tmo;

    task automatic m_finish(int code, bit ovf, bit tmo);
        m_phase = 0; m_valid = 1; m_code = code; m_ovf = ovf; m_tmo = tmo;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist = '{0, 0};
            m_phase = 0; m_el = 0; m_ticks = 0; m_sub = 0; m_code = 0;
            m_valid = 0; m_ovf = 0; m_tmo = 0;
        end else begin
            bit seen;
            seen = hist[0];
            void'(hist.pop_front());
            hist.push_back(cmp_i);
            if (m_phase == 0) begin
                if (start_i) begin
                    m_phase = 1; m_el = 0; m_ticks = 0; m_sub = 0;
                    m_valid = 0; m_ovf = 0; m_tmo = 0;
                end
            end else if (m_phase == 1) begin
                if (seen) begin m_phase = 2; m_sub = 0; end
                else if (m_el == TMO - 1) m_finish(m_code, 0, 1);
                m_el++;
            end else begin
                if (!seen) m_finish(m_ticks, 0, 0);
                else if (m_sub == DIV - 1 && m_ticks == 7) m_finish(7, 1, 0);
                else if (m_el == TMO - 1) m_finish(m_code, 0, 1);
                else if (m_sub == DIV - 1) begin m_ticks++; m_sub = 0; end
                else m_sub++;
                m_el++;
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R8 synchronizer timing)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(code_o == 3'(m_code), "R8 model code_o", code_o, m_code);
            chk(valid_o == m_valid, "R8 model valid_o", valid_o, m_valid);
            chk(step_en_o == (m_phase != 0), "R8 model step_en_o", step_en_o, m_phase != 0);
            chk(ovf_o == m_ovf, "R8 model ovf_o", ovf_o, m_ovf);
            chk(tmo_o == m_tmo, "R8 model tmo_o", tmo_o, m_tmo);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog R8 actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // a: cycles of low comparator, h: cycles high; second start pulse if again
    task automatic run(int a, int h, bit again, string tag,
                       int exp_code, bit exp_ovf, bit exp_tmo);
        int prev;
        prev = code_o;
        @(negedge clk); start_i = 1'b1; cmp_i = 1'b0;
        @(negedge clk); start_i = 1'b0;
        chk(step_en_o && !valid_o, {tag, " R2 step_en up, valid low"}, step_en_o, 1);
        for (int k = 0; k < 300 && !valid_o; k++) begin
            cmp_i   = (k >= a) && (k < a + h);
            start_i = again && (k == 3);
            if (k == 2) begin
                chk(code_o == 3'(prev), {tag, " R3 code held while busy"}, code_o, prev);
                chk(!valid_o, {tag, " R3 valid low while busy"}, valid_o, 0);
            end
            @(negedge clk);
        end
        cmp_i = 1'b0; start_i = 1'b0;
        chk(code_o == 3'(exp_code), {tag, " code_o"}, code_o, exp_code);
        chk(ovf_o == exp_ovf, {tag, " ovf_o"}, ovf_o, exp_ovf);
        chk(tmo_o == exp_tmo, {tag, " tmo_o"}, tmo_o, exp_tmo);
        chk(valid_o && !step_en_o, {tag, " R4 valid up, step_en down"}, valid_o, 1);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(code_o == 3'b000, "R1 reset code_o", code_o, 0);
        chk(!valid_o && !step_en_o && !ovf_o && !tmo_o, "R1 reset flags",
            {valid_o, step_en_o, ovf_o, tmo_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run(2, 6, 0, "R4 code 001", 1, 0, 0);
        run(1, 14, 0, "R4 code 011", 3, 0, 0);
        run(3, 30, 0, "R4 code 111", 7, 0, 0);
        run(2, 2, 0, "R4 code 000", 0, 0, 0);
        run(2, 40, 0, "R6 saturate", 7, 1, 0);
        run(1, 6, 0, "R4 after ovf", 1, 0, 0);
        run(500, 0, 0, "R7 timeout", 1, 0, 1);
        run(20, 10, 0, "R5 late arm", 2, 0, 0);
        run(0, 14, 1, "R2 restart ignored", 3, 0, 0);

        // R9: comparator toggling while idle leaves everything alone
        for (int k = 0; k < 12; k++) begin
            cmp_i = k[0];
            @(negedge clk);
        end
        cmp_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(code_o == 3'd3 && valid_o && !step_en_o, "R9 idle hold", code_o, 3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule